// File: doc/BRIEF.md
# Keyed Preloadable Watchdog Timer

This block is a hardware watchdog. It counts machine-cycle ticks in a wide up-counter. When the count reaches its all-ones value, it raises a one-clock system reset pulse. To keep that pulse from firing, software services the watchdog by writing a reload byte. The low seven bits of that byte are placed in the top of the counter, which shortens the remaining time by a chosen amount.

A separate 8-bit lock register decides whether the watchdog runs. One exact pattern, 55h, freezes it. Any other value lets it count. After reset the lock register holds 00h, so the watchdog runs with no enable step. The idle-mode input has no power to stop it.

Both registers share one synchronous write port: a write strobe, a one-bit select and a data byte. Decoding of processor addresses is done outside the block.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `wdt_rst` is low, the counter is zero and the lock register holds 00h, so the watchdog is running.
- R2: While running, each cycle with `tick_en` high advances the CNT_W-bit counter (22 bits by default) by exactly one. A cycle with `tick_en` low leaves it unchanged.
- R3: A tick that brings the counter to all-ones raises `wdt_rst` on the next cycle. In that same cycle the counter reads zero. From zero, the pulse comes on the (2^CNT_W − 1)-th tick.
- R4: A write with `wr_sel` = 0 and a data value from 00h to 7Eh loads data bits [6:0] into the top seven counter bits and clears all lower bits. Writing 00h therefore zeroes the counter.
- R5: A write with `wr_sel` = 0 and a data value above 7Eh leaves the counter unchanged.
- R6: A write with `wr_sel` = 1 stores the byte in the lock register. While the lock register holds 55h, the counter holds its value and `wdt_rst` stays low.
- R7: Writing any lock value other than 55h, including the neighbours 54h and 56h, resumes counting from the held value.
- R8: When `wdt_rst` fires, the lock register returns to 00h and the watchdog keeps running from zero.
- R9: The `idle` input has no effect: counting and pulse generation go on while it is high.
- R10: When a valid reload write and a tick fall in the same cycle, the counter takes the reload value and the tick is dropped.
- R11: `wdt_rst` is high for exactly one clock cycle per expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | Machine-cycle tick enable |
| idle | input | 1 | Idle-mode indication; does not gate the watchdog |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = reload (service) register, 1 = lock register |
| wr_data | input | 8 | Write data byte |
| wdt_rst | output | 1 | One-cycle system reset pulse on expiry |

## Verification
Two things can land on the counter in the same cycle: a service write and a machine-cycle tick. The bench provokes this by issuing the 7Eh reload with `tick_en` held high. It then counts the ticks up to the pulse. Exactly 63 ticks at the reduced 12-bit width means the reload won and the tick was dropped; 62 would mean the tick was applied as well. The checker also states that the expiry tick clears the lock register, and that this clear takes priority over any lock value written in that cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic {
    SEL_SVC  = 1'b0,
    SEL_LOCK = 1'b1
  } wdt_sel_e;

  localparam int unsigned DAT_W = 8;
  localparam logic [DAT_W-1:0] LOCK_OFF  = 8'h55;
  localparam logic [DAT_W-1:0] LOCK_INIT = 8'h00;

endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/wdt_wr_decode.sv
module wdt_wr_decode
  import wdt_pkg::*;
#(
  parameter int unsigned RLD_W = 7
) (
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [DAT_W-1:0] wr_data,
  output logic             svc_load,
  output logic [RLD_W-1:0] svc_val,
  output logic             lock_load
);

  localparam logic [DAT_W-1:0] RLD_LIMIT = DAT_W'((1 << RLD_W) - 2);

  wdt_sel_e sel;

  always_comb begin
    sel       = wdt_sel_e'(wr_sel);
    svc_load  = wr_en && (sel == SEL_SVC) && (wr_data <= RLD_LIMIT);
    lock_load = wr_en && (sel == SEL_LOCK);
    svc_val   = wr_data[RLD_W-1:0];
  end

endmodule

// File: rtl/wdt_lock_reg.sv
module wdt_lock_reg
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_load,
  input  logic [DAT_W-1:0] lock_val,
  input  logic             expire,
  output logic [DAT_W-1:0] lock_q,
  output logic             run_en
);

  logic [DAT_W-1:0] lock_d;
  logic             lock_ce;

  always_comb begin
    lock_ce = expire || lock_load;
    lock_d  = expire ? LOCK_INIT : lock_val;
    run_en  = (lock_q != LOCK_OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= LOCK_INIT;
    else if (lock_ce) lock_q <= lock_d;
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 22,
  parameter int unsigned RLD_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run_en,
  input  logic             svc_load,
  input  logic [RLD_W-1:0] svc_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire,
  output logic             pulse_q
);

  localparam int unsigned      LOW_W    = CNT_W - RLD_W;
  localparam logic [CNT_W-1:0] PRE_TERM = {{(CNT_W-1){1'b1}}, 1'b0};

  logic             step;
  logic             cnt_ce;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    step   = tick_en && run_en;
    expire = step && !svc_load && (cnt_q == PRE_TERM);
    cnt_ce = svc_load || step;
    if (svc_load)    cnt_d = {svc_val, {LOW_W{1'b0}}};
    else if (expire) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (cnt_ce) cnt_q <= cnt_d;
      pulse_q <= expire;
    end
  end

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 22,
  parameter int unsigned RLD_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       idle,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic       wdt_rst
);

  logic             rst_sync_n;
  logic             svc_load;
  logic [RLD_W-1:0] svc_val;
  logic             lock_load;
  logic [DAT_W-1:0] key_q;
  logic             run_en;
  logic [CNT_W-1:0] cnt_q;
  logic             expire;

  wdt_rst_sync #(.STAGES(2)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wdt_wr_decode #(.RLD_W(RLD_W)) u_dec (
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .svc_load  (svc_load),
    .svc_val   (svc_val),
    .lock_load (lock_load)
  );

  wdt_lock_reg u_lock (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .lock_load (lock_load),
    .lock_val  (wr_data),
    .expire    (expire),
    .lock_q    (key_q),
    .run_en    (run_en)
  );

  wdt_counter #(.CNT_W(CNT_W), .RLD_W(RLD_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick_en  (tick_en),
    .run_en   (run_en),
    .svc_load (svc_load),
    .svc_val  (svc_val),
    .cnt_q    (cnt_q),
    .expire   (expire),
    .pulse_q  (wdt_rst)
  );

endmodule

// File: rtl/keyed_watchdog_sva.sv
module keyed_watchdog_sva #(
  parameter int unsigned CNT_W = 22,
  parameter int unsigned RLD_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             idle,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [7:0]       wr_data,
  input logic             wdt_rst,
  input logic [CNT_W-1:0] cnt,
  input logic [7:0]       key
);

  localparam logic [7:0]       LIMIT    = 8'((1 << RLD_W) - 2);
  localparam logic [CNT_W-1:0] PRE_TERM = {{(CNT_W-1){1'b1}}, 1'b0};

  logic svc_ok;
  logic svc_bad;
  logic running;

  assign svc_ok  = wr_en && !wr_sel && (wr_data <= LIMIT);
  assign svc_bad = wr_en && !wr_sel && (wr_data > LIMIT);
  assign running = (key != 8'h55);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && running && !svc_ok && (cnt != PRE_TERM) |=> cnt == $past(cnt) + 1'b1);

  p_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && running && !svc_ok && (cnt == PRE_TERM) |=> wdt_rst && (cnt == '0));

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    svc_ok |=> (cnt[CNT_W-1 -: RLD_W] == $past(wr_data[RLD_W-1:0]))
               && (cnt[CNT_W-RLD_W-1:0] == '0));

  p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    svc_bad && !tick_en |=> $stable(cnt));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !svc_ok |=> $stable(cnt) && !wdt_rst);

  p_key_home_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> key == 8'h00);

  p_idle_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idle && tick_en && running && !svc_ok && (cnt != PRE_TERM)
    |=> cnt == $past(cnt) + 1'b1);

  p_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);

endmodule

bind keyed_watchdog keyed_watchdog_sva #(.CNT_W(CNT_W), .RLD_W(RLD_W)) u_sva (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .tick_en (tick_en),
  .idle    (idle),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .wr_data (wr_data),
  .wdt_rst (wdt_rst),
  .cnt     (cnt_q),
  .key     (key_q)
);

// File: tb/keyed_watchdog_tb_top.sv
module keyed_watchdog_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CW   = 12;
  localparam int RW   = 7;
  localparam int SH   = CW - RW;
  localparam int FULL = (1 << CW) - 1;

  logic       clk;
  logic       rst_n;
  logic       tick_en;
  logic       idle;
  logic       wr_en;
  logic       wr_sel;
  logic [7:0] wr_data;
  logic       wdt_rst;

  int n_run;
  int n_fail;

  keyed_watchdog #(.CNT_W(CW), .RLD_W(RW)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .idle    (idle),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .wdt_rst (wdt_rst)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Ticks n times (optionally with an idle gap cycle after each) and reports
  // the tick index of the first pulse and the number of pulse cycles seen.
  task automatic run(input int n, input bit gap, output int first, output int pulses);
    first = 0;
    pulses = 0;
    for (int k = 1; k <= n; k++) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      if (wdt_rst) begin
        pulses++;
        if (first == 0) first = k;
      end
      if (gap) begin
        @(negedge clk);
        if (wdt_rst) pulses++;
      end
    end
  endtask

  task automatic wr(input bit sel, input logic [7:0] data, input bit tk);
    wr_en   = 1'b1;
    wr_sel  = sel;
    wr_data = data;
    tick_en = tk;
    @(negedge clk);
    wr_en   = 1'b0;
    tick_en = 1'b0;
  endtask

  task automatic t_reset_and_full;
    int f, p;
    check(wdt_rst == 1'b0, "R1 pulse low after reset", int'(wdt_rst), 0);
    run(FULL + 1, 1'b0, f, p);
    check(f == FULL, "R1/R2/R3 first expiry from zero", f, FULL);
    check(p == 1, "R11 single pulse cycle", p, 1);
    run(FULL + 1, 1'b0, f, p);
    check(f == FULL - 1, "R8 runs again from zero after expiry", f, FULL - 1);
  endtask

  task automatic t_reload_with_tick;
    int f, p;
    wr(1'b0, 8'h7E, 1'b1);
    run(70, 1'b0, f, p);
    check(f == FULL - (8'h7E << SH), "R10/R4 reload beats tick", f, FULL - (8'h7E << SH));
    check(p == 1, "R11 one pulse after reload", p, 1);
  endtask

  task automatic t_reload_mid;
    int f, p;
    wr(1'b0, 8'h10, 1'b0);
    run(FULL - (8'h10 << SH) + 2, 1'b0, f, p);
    check(f == FULL - (8'h10 << SH), "R4 reload 10h timeout", f, FULL - (8'h10 << SH));
  endtask

  task automatic t_reload_zero;
    int f, p;
    run(100, 1'b0, f, p);
    wr(1'b0, 8'h00, 1'b0);
    run(FULL + 1, 1'b0, f, p);
    check(f == FULL, "R4 write 00h clears counter", f, FULL);
  endtask

  task automatic t_ignore_high;
    int f, p;
    wr(1'b0, 8'h7E, 1'b0);
    run(10, 1'b0, f, p);
    wr(1'b0, 8'h7F, 1'b0);
    wr(1'b0, 8'h80, 1'b0);
    wr(1'b0, 8'hFF, 1'b0);
    run(60, 1'b0, f, p);
    check(f == FULL - (8'h7E << SH) - 10, "R5 writes above 7Eh ignored", f,
          FULL - (8'h7E << SH) - 10);
  endtask

  task automatic t_lock;
    int f, p;
    wr(1'b0, 8'h7E, 1'b0);
    run(20, 1'b0, f, p);
    wr(1'b1, 8'h55, 1'b0);
    run(300, 1'b0, f, p);
    check(p == 0, "R6 no pulse while locked", p, 0);
    wr(1'b1, 8'h54, 1'b0);
    run(50, 1'b0, f, p);
    check(f == FULL - (8'h7E << SH) - 20, "R7 key 54h resumes from held value", f,
          FULL - (8'h7E << SH) - 20);
    wr(1'b0, 8'h7E, 1'b0);
    wr(1'b1, 8'h56, 1'b0);
    run(70, 1'b0, f, p);
    check(f == FULL - (8'h7E << SH), "R7 key 56h keeps running", f, FULL - (8'h7E << SH));
  endtask

  task automatic t_idle_gaps;
    int f, p;
    idle = 1'b1;
    wr(1'b0, 8'h7E, 1'b0);
    run(70, 1'b1, f, p);
    check(f == FULL - (8'h7E << SH), "R9/R2 idle and tick gaps", f, FULL - (8'h7E << SH));
    check(p == 1, "R11 single pulse with gaps", p, 1);
    idle = 1'b0;
  endtask

  bit done;

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run   = 0;
    n_fail  = 0;
    rst_n   = 1'b0;
    tick_en = 1'b0;
    idle    = 1'b0;
    wr_en   = 1'b0;
    wr_sel  = 1'b0;
    wr_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_and_full();
    t_reload_with_tick();
    t_reload_mid();
    t_reload_zero();
    t_ignore_high();
    t_lock();
    t_idle_gaps();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule